// File: doc/BRIEF.md
# Oscillator Pair Comparator with Masked Pair Selection

This block is the digital back end of an oscillator-based device fingerprint. The oscillators are free-running and arrive as asynchronous toggling inputs. Each one is resynchronised into the system clock domain. For one oscillator pair at a time, the block counts rising edges over a window set in system clocks and compares the two counts to form one response bit. Each response bit owns its own group of sixteen oscillators, arranged as eight candidate pairs, so no oscillator contributes to more than one bit.

The block has two modes. In enrollment it measures all eight pairs of the group in a fixed order and keeps the pair whose counts are furthest apart. It outputs that pair's bit and its 3-bit index, and the index may be stored as public helper data. In regeneration the stored index is supplied back, and only that pair is measured. Counts of other pairs and their distances play no part. A request starts with a one-cycle `start`, and the result comes with a one-cycle `done`.

Top module: `ro_pair_masker`

## Requirements
- R1: For response bit b and candidate pair j (0..7), the first oscillator is input 16*b+2*j and the second is input 16*b+2*j+1, so the groups of different bits share no oscillator.
- R2: Each selected oscillator passes through a two-flop synchroniser. Its rising edges are counted from zero over exactly `winLen` clocks (0 acts as 1). `respBit` is 1 only when the first count is strictly larger, and equal counts give 0.
- R3: With `regen`=0 (enroll), pairs 0..7 of the group are measured in order. The pair with the largest absolute count difference sets `respBit`, and its index appears on `maskIdx`.
- R4: When several pairs share the largest difference during enrollment, the lowest pair index wins.
- R5: With `regen`=1, only the pair given on `helperIn` is measured and `maskIdx` returns that index. The distances of the other pairs do not affect the result.
- R6: Each edge counter saturates at 2^CNT_W-1 and never wraps, so two saturated counts compare as a tie.
- R7: `done` is a one-cycle pulse. It rises winLen+2 clock edges after the edge that accepts `start` in regeneration, and 8*(winLen+2) edges after it in enrollment.
- R8: A `start` that arrives while a request is in progress is ignored and produces no extra result.
- R9: After reset, `done`, `respBit` and `maskIdx` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| oscIn | input | NUM_OSC | Asynchronous oscillator toggle inputs |
| start | input | 1 | Request pulse, accepted only when idle |
| regen | input | 1 | 0 = enroll, 1 = regenerate |
| bitIdx | input | BIT_W | Response bit (oscillator group) to produce |
| helperIn | input | 3 | Stored pair index used in regeneration |
| winLen | input | WIN_W | Measurement window in clocks |
| done | output | 1 | Result valid pulse |
| respBit | output | 1 | Response bit |
| maskIdx | output | 3 | Selected pair index (helper data) |

## Verification
The bench builds the block with NUM_OSC=32, CNT_W=6 and WIN_W=10. Two groups make it possible to show that one bit's pairs never leak into the other. The 6-bit counters reach saturation within a 400-clock window, so the saturation tie can be seen at the response bit. Oscillator pairs can be mirrored or cloned from identical waveforms, which produces exact count ties and exact distance ties.

// File: rtl/ro_pkg.sv
package ro_pkg;
  localparam int GROUP_SIZE  = 8;
  localparam int PAIR_W      = $clog2(GROUP_SIZE);
  localparam int OSC_PER_BIT = 2 * GROUP_SIZE;

  typedef struct packed {
    logic clrCnt;
    logic cntEn;
  } dpCtl_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CLEAR,
    S_MEAS,
    S_CMP
  } state_t;
endpackage

// File: rtl/ro_meas_path.sv
module ro_meas_path import ro_pkg::*; #(
  parameter int NUM_OSC = 64,
  parameter int CNT_W   = 16,
  parameter int BIT_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_OSC-1:0]  oscIn,
  input  dpCtl_t              ctl,
  input  logic [BIT_W-1:0]    bitSel,
  input  logic [PAIR_W-1:0]   pairSel,
  output logic [CNT_W-1:0]    cntA,
  output logic [CNT_W-1:0]    cntB,
  output logic [CNT_W-1:0]    absDiff,
  output logic                aGreater
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [NUM_OSC-1:0] sync1, sync2, sync3, rise;
  logic [CNT_W-1:0]   cnt [2];

  // two-flop synchroniser plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= oscIn;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  assign rise = sync2 & ~sync3;

  for (genvar k = 0; k < 2; k++) begin : g_cnt
    logic hit;
    assign hit = rise[{bitSel, pairSel, 1'(k)}];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cnt[k] <= '0;
      else if (ctl.clrCnt)
        cnt[k] <= '0;
      else if (ctl.cntEn && hit && (cnt[k] != CNT_MAX))
        cnt[k] <= cnt[k] + 1'b1;
    end
  end

  assign cntA     = cnt[0];
  assign cntB     = cnt[1];
  assign aGreater = cnt[0] > cnt[1];
  assign absDiff  = aGreater ? (cnt[0] - cnt[1]) : (cnt[1] - cnt[0]);
endmodule

// File: rtl/ro_pair_ctrl.sv
module ro_pair_ctrl import ro_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16,
  parameter int BIT_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              regen,
  input  logic [BIT_W-1:0]  bitIdx,
  input  logic [PAIR_W-1:0] helperIn,
  input  logic [WIN_W-1:0]  winLen,
  input  logic [CNT_W-1:0]  absDiff,
  input  logic              aGreater,
  output dpCtl_t            ctl,
  output logic [BIT_W-1:0]  bitSel,
  output logic [PAIR_W-1:0] pairSel,
  output logic              done,
  output logic              respBit,
  output logic [PAIR_W-1:0] maskIdx
);
  state_t             state;
  logic               modeR;
  logic [WIN_W-1:0]   winR, winCnt;
  logic [PAIR_W-1:0]  pairR, bestIdx;
  logic [CNT_W-1:0]   bestDiff;
  logic               bestBit;

  logic              takeNew, lastPair, winEnd, candBit;
  logic [PAIR_W-1:0] candIdx;
  logic [WIN_W:0]    nextCnt;

  assign nextCnt  = {1'b0, winCnt} + (WIN_W+1)'(1);
  assign winEnd   = nextCnt >= {1'b0, winR};
  assign lastPair = modeR || (pairR == PAIR_W'(GROUP_SIZE - 1));
  assign takeNew  = modeR || (pairR == '0) || (absDiff > bestDiff);
  assign candBit  = takeNew ? aGreater : bestBit;
  assign candIdx  = takeNew ? pairR : bestIdx;

  assign ctl.clrCnt = (state == S_CLEAR);
  assign ctl.cntEn  = (state == S_MEAS);
  assign bitSel     = bitR;
  assign pairSel    = pairR;

  logic [BIT_W-1:0] bitR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      modeR    <= 1'b0;
      bitR     <= '0;
      winR     <= '0;
      winCnt   <= '0;
      pairR    <= '0;
      bestIdx  <= '0;
      bestDiff <= '0;
      bestBit  <= 1'b0;
      done     <= 1'b0;
      respBit  <= 1'b0;
      maskIdx  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        S_IDLE: if (start) begin
          modeR <= regen;
          bitR  <= bitIdx;
          winR  <= winLen;
          pairR <= regen ? helperIn : '0;
          state <= S_CLEAR;
        end
        S_CLEAR: begin
          winCnt <= '0;
          state  <= S_MEAS;
        end
        S_MEAS: begin
          winCnt <= nextCnt[WIN_W-1:0];
          if (winEnd) state <= S_CMP;
        end
        S_CMP: begin
          bestDiff <= takeNew ? absDiff : bestDiff;
          bestBit  <= candBit;
          bestIdx  <= candIdx;
          if (lastPair) begin
            done    <= 1'b1;
            respBit <= candBit;
            maskIdx <= candIdx;
            state   <= S_IDLE;
          end else begin
            pairR <= pairR + 1'b1;
            state <= S_CLEAR;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ro_pair_masker.sv
module ro_pair_masker import ro_pkg::*; #(
  parameter int NUM_OSC = 64,
  parameter int CNT_W   = 16,
  parameter int WIN_W   = 16,
  localparam int BIT_W  = $clog2(NUM_OSC / OSC_PER_BIT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_OSC-1:0] oscIn,
  input  logic               start,
  input  logic               regen,
  input  logic [BIT_W-1:0]   bitIdx,
  input  logic [PAIR_W-1:0]  helperIn,
  input  logic [WIN_W-1:0]   winLen,
  output logic               done,
  output logic               respBit,
  output logic [PAIR_W-1:0]  maskIdx
);
  dpCtl_t            dpCtl;
  logic [BIT_W-1:0]  bitSel;
  logic [PAIR_W-1:0] pairSel;
  logic [CNT_W-1:0]  cntA, cntB, absDiff;
  logic              aGreater;

  ro_pair_ctrl #(.CNT_W(CNT_W), .WIN_W(WIN_W), .BIT_W(BIT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .regen(regen), .bitIdx(bitIdx),
    .helperIn(helperIn), .winLen(winLen), .absDiff(absDiff), .aGreater(aGreater),
    .ctl(dpCtl), .bitSel(bitSel), .pairSel(pairSel), .done(done),
    .respBit(respBit), .maskIdx(maskIdx)
  );

  ro_meas_path #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .BIT_W(BIT_W)) u_path (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .ctl(dpCtl), .bitSel(bitSel),
    .pairSel(pairSel), .cntA(cntA), .cntB(cntB), .absDiff(absDiff),
    .aGreater(aGreater)
  );
endmodule

// File: rtl/ro_pair_masker_chk.sv
module ro_pair_masker_chk import ro_pkg::*; #(
  parameter int CNT_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              done,
  input logic [CNT_W-1:0]  cntA,
  input logic [CNT_W-1:0]  cntB,
  input logic              clrCnt,
  input logic              cntEn,
  input logic [PAIR_W-1:0] pairSel
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R7: result strobe lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R2: window starts from zero counts
  p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    clrCnt |=> (cntA == '0) && (cntB == '0));

  // R2: counts hold outside the window
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cntEn && !clrCnt) |=> $stable(cntA) && $stable(cntB));

  // R2: at most one edge counted per clock
  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !clrCnt) |=> (cntA == $past(cntA) || cntA == $past(cntA) + 1'b1));

  // R6: saturated counter never wraps
  p_sat_a_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !clrCnt && cntA == CNT_MAX) |=> cntA == CNT_MAX);

  p_sat_b_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !clrCnt && cntB == CNT_MAX) |=> cntB == CNT_MAX);

  // R1: the measured pair does not change inside a window
  p_pair_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    cntEn |=> (!cntEn || $stable(pairSel)));
endmodule

bind ro_pair_masker ro_pair_masker_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .done(done), .cntA(cntA), .cntB(cntB),
  .clrCnt(dpCtl.clrCnt), .cntEn(dpCtl.cntEn), .pairSel(pairSel)
);

// File: tb/tb_ro_pair_masker.sv
`timescale 1ns/1ps
module tb_ro_pair_masker;
  localparam int NUM_OSC = 32;
  localparam int CNT_W   = 6;
  localparam int WIN_W   = 10;
  localparam int NPAIR   = NUM_OSC / 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_OSC-1:0] oscIn;
  logic start = 1'b0, regen = 1'b0;
  logic [0:0] bitIdx = '0;
  logic [2:0] helperIn = '0;
  logic [WIN_W-1:0] winLen = '0;
  logic done, respBit;
  logic [2:0] maskIdx;

  always #2.5 clk = ~clk;

  ro_pair_masker #(.NUM_OSC(NUM_OSC), .CNT_W(CNT_W), .WIN_W(WIN_W)) dut (
    .clk(clk), .rstN(rstN), .oscIn(oscIn), .start(start), .regen(regen),
    .bitIdx(bitIdx), .helperIn(helperIn), .winLen(winLen), .done(done),
    .respBit(respBit), .maskIdx(maskIdx)
  );

  // oscillator models
  int   halfNs [NUM_OSC];
  int   srcPair [NPAIR];
  bit   mirror [NPAIR];
  logic oscRaw [NUM_OSC];

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    initial begin
      oscRaw[g] = 1'b0;
      #(1 + g % 4);
      forever #(halfNs[g]) oscRaw[g] = ~oscRaw[g];
    end
  end

  always_comb begin
    for (int p = 0; p < NPAIR; p++) begin
      oscIn[2*p]   = oscRaw[2*srcPair[p]];
      oscIn[2*p+1] = mirror[p] ? oscRaw[2*srcPair[p]] : oscRaw[2*srcPair[p]+1];
    end
  end

  // scoreboard
  typedef struct {
    bit    eBit;
    int    eIdx;
    int    eLat;
    string tag;
  } item_t;
  item_t expQ [$];

  int nChecks = 0, nErr = 0, doneCnt = 0;
  int cyc = 0, acceptCyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic checkEq(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rstN && done) begin
        doneCnt++;
        if (expQ.size() == 0) begin
          checkEq("R8", "unexpected done", 1, 0);
        end else begin
          item_t it;
          it = expQ.pop_front();
          checkEq(it.tag, "respBit", int'(respBit), int'(it.eBit));
          checkEq(it.tag, "maskIdx", int'(maskIdx), it.eIdx);
          checkEq("R7", "latency", cyc - acceptCyc, it.eLat);
        end
      end
    end
  end

  task automatic setPair(int p, int hA, int hB);
    halfNs[2*p]   = hA;
    halfNs[2*p+1] = hB;
  endtask

  task automatic request(bit rg, int b, int helper, int win, bit eBit, int eIdx,
                         string tag, bit poke = 1'b0);
    item_t it;
    it.eBit = eBit;
    it.eIdx = eIdx;
    it.eLat = rg ? win + 2 : 8 * (win + 2);
    it.tag  = tag;
    expQ.push_back(it);
    @(negedge clk);
    regen = rg; bitIdx = 1'(b); helperIn = 3'(helper); winLen = WIN_W'(win);
    start = 1'b1;
    @(posedge clk);
    #1 acceptCyc = cyc;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R8: second start while busy, with other settings
      repeat (10) @(negedge clk);
      regen = ~rg; helperIn = 3'd7; winLen = WIN_W'(5);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (expQ.size() == 0);
    repeat (20) @(negedge clk);
  endtask

  initial begin
    #500000;
    nErr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPAIR; p++) begin
      srcPair[p] = p;
      mirror[p]  = 1'b0;
      setPair(p, 10, 11);
    end
    repeat (4) @(negedge clk);
    // R9: reset state
    checkEq("R9", "done", int'(done), 0);
    checkEq("R9", "respBit", int'(respBit), 0);
    checkEq("R9", "maskIdx", int'(maskIdx), 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R3/R1: enroll bit 0, pair 5 (osc 10,11) far apart, first faster
    setPair(5, 6, 20);
    request(1'b0, 0, 0, 60, 1'b1, 5, "R3");
    // R1: enroll bit 1, pair 2 (osc 20,21) far apart, second faster; bit0 pair5 must not leak
    setPair(10, 20, 6);
    request(1'b0, 1, 0, 60, 1'b0, 2, "R1");

    // R5: regeneration measures only the stored pair
    setPair(3, 6, 20);
    setPair(5, 20, 6);
    request(1'b1, 0, 3, 60, 1'b1, 3, "R5");
    request(1'b1, 0, 5, 60, 1'b0, 5, "R5");

    // R2: identical waveforms give a tie, resolved to 0
    mirror[12] = 1'b1;
    request(1'b1, 1, 4, 60, 1'b0, 4, "R2");
    mirror[12] = 1'b0;

    // R4: pairs 4 and 6 of bit 1 share the largest distance
    setPair(10, 10, 11);
    setPair(12, 6, 20);
    srcPair[14] = 12;
    request(1'b0, 1, 0, 60, 1'b1, 4, "R4");
    srcPair[14] = 14;

    // R4/R2: all distances zero, lowest index, tie bit 0
    for (int p = 8; p < 16; p++) mirror[p] = 1'b1;
    request(1'b0, 1, 0, 60, 1'b0, 0, "R4");
    for (int p = 8; p < 16; p++) mirror[p] = 1'b0;

    // R6: short window resolves, long window saturates both counts
    setPair(0, 6, 9);
    request(1'b1, 0, 0, 60, 1'b1, 0, "R6");
    request(1'b1, 0, 0, 400, 1'b0, 0, "R6");

    // R8: start during enrollment is ignored
    setPair(5, 10, 11);
    request(1'b0, 0, 0, 60, 1'b1, 3, "R8", 1'b1);
    repeat (100) @(negedge clk);
    checkEq("R8", "done count", doneCnt, 10);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule